// File: doc/BRIEF.md
# Single-Bit Test and Modify Unit

This block performs one of four single-bit operations on an operand: test, toggle, clear or set. Each operation is given a bit number, a two-bit operation code, an operand and the current condition-code register. A decoder in a processor execution stage presents these inputs for one cycle with a strobe. One clock later the block returns the modified operand, a write-enable for that result and updated condition codes. A done pulse marks the same cycle.

The bit number is reduced differently for the two operand kinds. When the operand comes from a 32-bit data register, the number is taken modulo 32. When it is a byte fetched from memory, the number is taken modulo 8. Only the zero flag changes. It reports the inverse of the selected bit as it was before the modification. The bit number can come from a register or from an immediate field; in both cases it arrives on `bit_sel`. Address calculation and bus traffic are handled outside the block.

Top module: `bit_op_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `done`, `result_we`, `result` and `ccr_out` become zero on that edge.
- R2: A rising clock edge with `in_valid` high makes `done` high for exactly the following cycle. A cycle without `in_valid` leaves `done` low in the next cycle.
- R3: When `is_mem` is 0 (register operand), the selected bit index is `bit_sel` modulo 32.
- R4: When `is_mem` is 1 (memory byte), the selected bit index is `bit_sel` modulo 8. Bits 31:8 of `result` equal bits 31:8 of `operand`.
- R5: `ccr_out` bit 2 (Z) is 1 when the selected bit of the original operand is 0, and 0 when that bit is 1.
- R6: `ccr_out` bits 4 (X), 3 (N), 1 (V) and 0 (C) equal the same bits of `ccr_in`.
- R7: With `op_kind` 2'b00 (test), `result` equals `operand` and `result_we` stays 0.
- R8: With `op_kind` 2'b01 (toggle), `result` is `operand` with the selected bit inverted.
- R9: With `op_kind` 2'b10 (clear), `result` is `operand` with the selected bit forced to 0.
- R10: With `op_kind` 2'b11 (set), `result` is `operand` with the selected bit forced to 1. For toggle, clear and set, `result_we` is high exactly in the `done` cycle.
- R11: While `in_valid` is low, changes on the data inputs leave `result` and `ccr_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Strobe: the inputs in this cycle form a request |
| op_kind | input | 2 | 00 test, 01 toggle, 10 clear, 11 set |
| is_mem | input | 1 | 1 = byte operand from memory, 0 = 32-bit register operand |
| bit_sel | input | 32 | Raw bit number before wrapping |
| operand | input | 32 | Value to test and modify |
| ccr_in | input | 5 | Condition codes {X,N,Z,V,C} |
| done | output | 1 | One-cycle pulse, one clock after a strobe |
| result_we | output | 1 | Result must be written back |
| result | output | 32 | Modified operand |
| ccr_out | output | 5 | Updated condition codes {X,N,Z,V,C} |

## Verification
Each operation code runs with the chosen bit both set and clear. This separates a Z flag taken from the original value from one taken from the modified value. Bit numbers of 32 or more, and numbers of 8 to 15 on byte operands, confirm that each operand kind wraps with its own modulus. A memory-mode test whose register-mode bit would read differently rules out the wrong modulus. Condition codes enter with the other flags set in different mixes, which shows that only Z moves. Inputs that change while the strobe is low show that the outputs hold.

// File: rtl/bit_op_pkg.sv
// Package: shared constants and types for the single-bit test/modify unit.
// Assumes condition codes are ordered {X,N,Z,V,C} from bit 4 down to bit 0.
package bit_op_pkg;

    localparam int CCR_W   = 5;
    localparam int CCR_C   = 0;
    localparam int CCR_V   = 1;
    localparam int CCR_Z   = 2;
    localparam int CCR_N   = 3;
    localparam int CCR_X   = 4;

    // Operation code as carried in the instruction's type field
    typedef enum logic [1:0] {
        BOP_TEST   = 2'b00,
        BOP_TOGGLE = 2'b01,
        BOP_CLEAR  = 2'b10,
        BOP_SET    = 2'b11
    } bop_kind_e;

endpackage

// File: rtl/bit_op_mask_gen.sv
// Module: turns a raw bit number into a one-hot mask over the operand.
// Register operands wrap the number modulo DATA_W, byte operands modulo
// BYTE_W. Assumes DATA_W and BYTE_W are powers of two and BYTE_W <= DATA_W.
module bit_op_mask_gen #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int SEL_W  = 32
) (
    input  logic [SEL_W-1:0]  bit_sel,
    input  logic              is_mem,
    output logic [DATA_W-1:0] mask
);
    localparam int REG_IDX_W = $clog2(DATA_W);
    localparam int MEM_IDX_W = $clog2(BYTE_W);

    logic [REG_IDX_W-1:0] reg_idx;
    logic [MEM_IDX_W-1:0] mem_idx;
    logic [REG_IDX_W-1:0] idx;

    // Reduce the raw number for each operand kind and pick one
    always_comb begin
        reg_idx = REG_IDX_W'(bit_sel % SEL_W'(DATA_W));
        mem_idx = MEM_IDX_W'(bit_sel % SEL_W'(BYTE_W));
        idx     = is_mem ? REG_IDX_W'(mem_idx) : reg_idx;
    end

    // One comparator per operand bit forms the one-hot mask
    for (genvar g = 0; g < DATA_W; g++) begin : g_mask_bit
        assign mask[g] = (idx == REG_IDX_W'(g));
    end

endmodule

// File: rtl/bit_op_alu.sv
// Module: applies a one-hot mask to the operand for the requested operation
// and derives the zero flag from the original operand. Purely combinational;
// assumes the mask has exactly one bit set.
module bit_op_alu
    import bit_op_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  bop_kind_e         kind,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] value,
    output logic              zero,
    output logic              write
);
    // Zero flag reflects the selected bit before modification
    always_comb begin
        zero = ~|(operand & mask);
    end

    // Form the new value and decide whether it must be written back
    always_comb begin
        unique case (kind)
            BOP_TOGGLE: begin value = operand ^ mask;  write = 1'b1; end
            BOP_CLEAR:  begin value = operand & ~mask; write = 1'b1; end
            BOP_SET:    begin value = operand | mask;  write = 1'b1; end
            default:    begin value = operand;         write = 1'b0; end
        endcase
    end

endmodule

// File: rtl/bit_op_unit.sv
// Module: top of the single-bit test/modify unit. Captures one request per
// in_valid strobe and presents result, write-enable and condition codes one
// clock later with a done pulse. Outputs hold between requests. Assumes a
// synchronous active-low reset.
module bit_op_unit
    import bit_op_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int SEL_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op_kind,
    input  logic              is_mem,
    input  logic [SEL_W-1:0]  bit_sel,
    input  logic [DATA_W-1:0] operand,
    input  logic [CCR_W-1:0]  ccr_in,
    output logic              done,
    output logic              result_we,
    output logic [DATA_W-1:0] result,
    output logic [CCR_W-1:0]  ccr_out
);
    localparam logic [CCR_W-1:0] Z_ONLY = CCR_W'(1) << CCR_Z;

    logic [DATA_W-1:0] mask_w;
    logic [DATA_W-1:0] value_w;
    logic              zero_w;
    logic              write_w;
    logic [CCR_W-1:0]  ccr_next;
    bop_kind_e         kind_w;

    assign kind_w = bop_kind_e'(op_kind);

    bit_op_mask_gen #(
        .DATA_W (DATA_W),
        .BYTE_W (BYTE_W),
        .SEL_W  (SEL_W)
    ) u_mask (
        .bit_sel (bit_sel),
        .is_mem  (is_mem),
        .mask    (mask_w)
    );

    bit_op_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .kind    (kind_w),
        .operand (operand),
        .mask    (mask_w),
        .value   (value_w),
        .zero    (zero_w),
        .write   (write_w)
    );

    // Replace only the Z position of the incoming condition codes
    always_comb begin
        ccr_next = (ccr_in & ~Z_ONLY) | (zero_w ? Z_ONLY : '0);
    end

    // Done and write-enable are single-cycle pulses per strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            result_we <= 1'b0;
        end else begin
            done      <= in_valid;
            result_we <= in_valid & write_w;
        end
    end

    // Result and flags are captured on a strobe and held otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result  <= '0;
            ccr_out <= '0;
        end else if (in_valid) begin
            result  <= value_w;
            ccr_out <= ccr_next;
        end
    end

    // R3: the mask selects exactly one bit
    a_r3_mask_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> $onehot(mask_w));

    // R4: a byte operand never selects a bit above the byte
    a_r4_mem_mask_in_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_mem) |-> (mask_w[DATA_W-1:BYTE_W] == '0));

    // R2: a strobe produces done in the next cycle
    a_r2_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> done);

    // R2: no done without a strobe
    a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !done);

    // R7: a test leaves the operand untouched and requests no write
    a_r7_test_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_kind == 2'b00) |=> (!result_we && result == $past(operand)));

    // R10: the write-enable only appears with done
    a_r10_we_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        result_we |-> done);

    // R6: flags other than Z pass through
    a_r6_other_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((ccr_out & ~Z_ONLY) == ($past(ccr_in) & ~Z_ONLY)));

    // R11: outputs hold while no request arrives
    a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(ccr_out)));

endmodule

// File: tb/bit_op_unit_bench.sv
module bit_op_unit_bench;

    typedef struct packed {
        logic [1:0]  op;
        logic        mem;
        logic [4:0]  ccr;
        logic [31:0] sel;
        logic [31:0] opnd;
        logic [31:0] res;
        logic        we;
        logic [4:0]  ccr_o;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{2'b00, 1'b0, 5'b10000, 32'd5,          32'h0000_0020, 32'h0000_0020, 1'b0, 5'b10000},
        '{2'b00, 1'b0, 5'b01011, 32'd37,         32'h0000_0000, 32'h0000_0000, 1'b0, 5'b01111},
        '{2'b01, 1'b0, 5'b00000, 32'd31,         32'h8000_0001, 32'h0000_0001, 1'b1, 5'b00000},
        '{2'b01, 1'b0, 5'b00100, 32'h40,         32'h1234_5670, 32'h1234_5671, 1'b1, 5'b00100},
        '{2'b10, 1'b1, 5'b11111, 32'd11,         32'hAAAA_AA0F, 32'hAAAA_AA07, 1'b1, 5'b11011},
        '{2'b11, 1'b1, 5'b00000, 32'd15,         32'h5555_5500, 32'h5555_5580, 1'b1, 5'b00100},
        '{2'b11, 1'b0, 5'b10001, 32'd15,         32'h0000_8000, 32'h0000_8000, 1'b1, 5'b10001},
        '{2'b10, 1'b0, 5'b00100, 32'd33,         32'hFFFF_FFFF, 32'hFFFF_FFFD, 1'b1, 5'b00000},
        '{2'b00, 1'b1, 5'b01000, 32'd8,          32'h0000_0100, 32'h0000_0100, 1'b0, 5'b01100},
        '{2'b01, 1'b1, 5'b00000, 32'hFFFF_FFFE,  32'hFFFF_FF00, 32'hFFFF_FF40, 1'b1, 5'b00100}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [1:0]  op_kind;
    logic        is_mem;
    logic [31:0] bit_sel;
    logic [31:0] operand;
    logic [4:0]  ccr_in;
    logic        done;
    logic        result_we;
    logic [31:0] result;
    logic [4:0]  ccr_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bit_op_unit u_bit_op_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_kind   (op_kind),
        .is_mem    (is_mem),
        .bit_sel   (bit_sel),
        .operand   (operand),
        .ccr_in    (ccr_in),
        .done      (done),
        .result_we (result_we),
        .result    (result),
        .ccr_out   (ccr_out)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string res_tag(input logic [1:0] op, input logic mem);
        string t;
        case (op)
            2'b00:   t = "R7 test";
            2'b01:   t = "R8 toggle";
            2'b10:   t = "R9 clear";
            default: t = "R10 set";
        endcase
        return mem ? {t, " R4 byte"} : {t, " R3 reg"};
    endfunction

    task automatic strobe(input logic [1:0] op, input logic mem, input logic [4:0] cc,
                          input logic [31:0] sel, input logic [31:0] opnd);
        op_kind  = op;
        is_mem   = mem;
        ccr_in   = cc;
        bit_sel  = sel;
        operand  = opnd;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] held_res;
        logic [4:0]  held_ccr;
        rst_n = 1'b0; in_valid = 1'b0; op_kind = 2'b00; is_mem = 1'b0;
        bit_sel = '0; operand = '0; ccr_in = '0;
        repeat (3) @(negedge clk);

        // R1: reset state
        chk(done == 1'b0 && result_we == 1'b0, "R1 reset pulses", {30'd0, done, result_we}, 32'd0);
        chk(result == 32'd0 && ccr_out == 5'd0, "R1 reset data", result | {27'd0, ccr_out}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R3..R10 via result, write-enable and flags
        for (int i = 0; i < NVEC; i++) begin
            strobe(VECS[i].op, VECS[i].mem, VECS[i].ccr, VECS[i].sel, VECS[i].opnd);
            chk(done == 1'b1, "R2 done pulse", {31'd0, done}, 32'd1);
            chk(result == VECS[i].res, res_tag(VECS[i].op, VECS[i].mem), result, VECS[i].res);
            chk(result_we == VECS[i].we, "R10 R7 write enable", {31'd0, result_we}, {31'd0, VECS[i].we});
            chk(ccr_out[2] == VECS[i].ccr_o[2], "R5 zero flag", {31'd0, ccr_out[2]}, {31'd0, VECS[i].ccr_o[2]});
            chk(ccr_out == VECS[i].ccr_o, "R6 flags kept", {27'd0, ccr_out}, {27'd0, VECS[i].ccr_o});
            @(negedge clk);
            chk(done == 1'b0 && result_we == 1'b0, "R2 single pulse", {30'd0, done, result_we}, 32'd0);
        end

        // R11: idle input changes do not disturb held outputs
        held_res = result;
        held_ccr = ccr_out;
        op_kind = 2'b11; is_mem = 1'b0; bit_sel = 32'd3; operand = 32'h0F0F_0F0F; ccr_in = 5'b11111;
        repeat (3) @(negedge clk);
        chk(result == held_res, "R11 result held", result, held_res);
        chk(ccr_out == held_ccr, "R11 flags held", {27'd0, ccr_out}, {27'd0, held_ccr});
        chk(done == 1'b0, "R2 no done while idle", {31'd0, done}, 32'd0);

        // R4: byte mode on bit number 9 touches bit 1, upper bits kept
        strobe(2'b11, 1'b1, 5'b00000, 32'd9, 32'hDEAD_BE00);
        chk(result == 32'hDEAD_BE02, "R4 byte wrap set", result, 32'hDEAD_BE02);
        // R3: same number in register mode touches bit 9
        strobe(2'b11, 1'b0, 5'b00000, 32'd9, 32'hDEAD_BC00);
        chk(result == 32'hDEAD_BE00, "R3 reg index 9", result, 32'hDEAD_BE00);

        // R2: back-to-back strobes each give done
        op_kind = 2'b01; is_mem = 1'b0; bit_sel = 32'd0; operand = 32'h0; ccr_in = 5'b0;
        in_valid = 1'b1;
        @(negedge clk);
        chk(done == 1'b1 && result == 32'h1, "R2 back-to-back first", result, 32'h1);
        operand = 32'h1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(done == 1'b1 && result == 32'h0 && ccr_out[2] == 1'b0, "R2 back-to-back second", result, 32'h0);

        // R1: reset in mid-run clears outputs
        strobe(2'b11, 1'b0, 5'b11111, 32'd4, 32'h0);
        rst_n = 1'b0;
        @(negedge clk);
        chk(result == 32'd0 && ccr_out == 5'd0 && done == 1'b0, "R1 mid-run reset", result, 32'd0);
        rst_n = 1'b1;

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule